// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two 32-bit operands over several clock cycles and returns the 64-bit product as a high word and a low word. Each request states whether the operands are two's-complement or unsigned. A signed request is reduced to magnitudes first. The magnitudes are multiplied without sign, and the 64-bit result is negated at the end when the operand signs differ.

The first operand is the multiplier. It is scanned one bit per cycle, starting at the least significant bit. For each set bit, the second operand is added to the accumulator, shifted to match that bit's position. The scan stops on the cycle that adds the highest set multiplier bit. Small multipliers therefore finish in few cycles. A zero operand finishes with no iterations at all.

A client pulses `start` while the block is idle and then waits for the one-cycle `done` pulse. After that pulse, `hi` and `lo` keep their values until the next accepted request.

Top module: `seq_shift_mul`

## Requirements
- R1: After reset, `busy` and `done` are low, and `hi` and `lo` are zero.
- R2: If either operand is zero when a request is accepted, `done` is high in the cycle right after the accepting edge, `hi` and `lo` are zero, and `busy` never rises.
- R3: With `sgn` low, both operands are unsigned, and {`hi`,`lo`} equals their full 64-bit product when `done` is high.
- R4: With `sgn` high, both operands are two's-complement, and {`hi`,`lo`} equals their 64-bit two's-complement product when `done` is high.
- R5: For a nonzero request whose result is non-negative, `done` comes N cycles after the accepting edge. N is one plus the bit position of the highest set bit in the magnitude of `a`. `busy` is high in every cycle from the accepting edge until `done`, and low while `done` is high.
- R6: `done` is high for exactly one cycle per accepted request.
- R7: A `start` that arrives while `busy` is high is ignored. The request in progress keeps its result and its timing.
- R8: While the block is idle and `start` is low, `hi` and `lo` do not change, whatever the operand inputs do.
- R9: In signed mode, an operand equal to 0x80000000 is handled as magnitude 2^31. For example, 0x80000000 times 0xFFFFFFFF gives 0x0000000080000000.
- R10: A nonzero signed request whose operand signs differ takes one more cycle than R5 states. This extra cycle forms the negative result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request; accepted only while idle |
| a | input | W | Multiplier operand |
| b | input | W | Multiplicand operand |
| sgn | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| busy | output | 1 | Iteration or negation in progress |
| done | output | 1 | One-cycle pulse: result valid |
| hi | output | W | Upper word of the product |
| lo | output | W | Lower word of the product |

## Verification
A result is due 0 cycles after the accepting edge for a zero operand. Otherwise it is due after one cycle per scanned multiplier bit, plus one cycle when the result is negative. The bench computes this count from the operands alone. It then counts falling edges from the accepting edge up to the first sampled `done` and compares the two counts. The product is read at that same falling edge. The edge after it is used to confirm that `done` has dropped and that the outputs hold.

// File: rtl/seq_shift_mul.sv
module seq_shift_mul #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sgn,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST_STEP = CW'(W - 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_NEG} st_t;

  st_t            st;
  logic [2*W-1:0] mcand;
  logic [W-1:0]   mplier;
  logic [CW-1:0]  step;
  logic           neg;

  wire a_neg = sgn & a[W-1];
  wire b_neg = sgn & b[W-1];
  wire [W-1:0] a_mag = a_neg ? (~a + 1'b1) : a;
  wire [W-1:0] b_mag = b_neg ? (~b + 1'b1) : b;
  wire accept  = start && (st == S_IDLE);
  wire zero_op = (a == '0) || (b == '0);

  wire [2*W-1:0] addend  = mplier[0] ? mcand : '0;
  wire [2*W-1:0] acc_sum = {hi, lo} + addend;
  wire           last    = (mplier[0] && (mplier[W-1:1] == '0)) || (step == LAST_STEP);

  wire [W-1:0] lo_neg = ~lo + 1'b1;
  wire [W-1:0] hi_neg = ~hi + {{(W-1){1'b0}}, (lo_neg == '0)};

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      mcand  <= '0;
      mplier <= '0;
      step   <= '0;
      neg    <= 1'b0;
      hi     <= '0;
      lo     <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (accept) begin
            hi  <= '0;
            lo  <= '0;
            neg <= a_neg ^ b_neg;
            if (zero_op) begin
              done <= 1'b1;
            end else begin
              mcand  <= {{W{1'b0}}, b_mag};
              mplier <= a_mag;
              step   <= '0;
              st     <= S_RUN;
            end
          end
        end
        S_RUN: begin
          {hi, lo} <= acc_sum;
          mcand    <= mcand << 1;
          mplier   <= mplier >> 1;
          step     <= step + 1'b1;
          if (last) begin
            if (neg) begin
              st <= S_NEG;
            end else begin
              st   <= S_IDLE;
              done <= 1'b1;
            end
          end
        end
        S_NEG: begin
          hi   <= hi_neg;
          lo   <= lo_neg;
          st   <= S_IDLE;
          done <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/seq_shift_mul_chk.sv
module seq_shift_mul_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] hi,
  input logic [W-1:0] lo
);
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_not_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  p_zero_op_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && ((a == '0) || (b == '0))) |=> (done && !busy && hi == '0 && lo == '0));

  p_run_begins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (a != '0) && (b != '0)) |=> (busy && !done));

  p_ignore_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));

  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(hi) && $stable(lo) && !busy));
endmodule

bind seq_shift_mul seq_shift_mul_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .a(a), .b(b),
  .busy(busy), .done(done), .hi(hi), .lo(lo)
);

// File: tb/test_seq_shift_mul.sv
module test_seq_shift_mul;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] a = '0;
  logic [31:0] b = '0;
  logic        sgn = 1'b0;
  logic        busy, done;
  logic [31:0] hi, lo;
  int nchk = 0;
  int nerr = 0;

  always #10 clk = ~clk;

  seq_shift_mul #(.W(32)) i_seq_shift_mul (
    .clk(clk), .rst_n(rst_n), .start(start), .a(a), .b(b), .sgn(sgn),
    .busy(busy), .done(done), .hi(hi), .lo(lo)
  );

  // {a, b, sgn}
  localparam logic [64:0] VEC [11] = '{
    {32'h00000003, 32'h00000005, 1'b0},
    {32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0},
    {32'hFFFFFFF9, 32'h00000006, 1'b1},
    {32'hFFFFFFF9, 32'hFFFFFFFA, 1'b1},
    {32'h80000000, 32'h00000002, 1'b1},
    {32'h80000000, 32'hFFFFFFFF, 1'b1},
    {32'h12345678, 32'h9ABCDEF0, 1'b0},
    {32'h00000001, 32'hDEADBEEF, 1'b1},
    {32'h00000000, 32'h00000055, 1'b1},
    {32'hFFFFFFFF, 32'h00000000, 1'b0},
    {32'hFFFFFFFF, 32'h00000001, 1'b1}
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_prod(input logic [31:0] x, input logic [31:0] y, input logic s);
    logic signed [63:0] sx, sy;
    if (s) begin
      sx = $signed({{32{x[31]}}, x});
      sy = $signed({{32{y[31]}}, y});
      return sx * sy;
    end
    return {32'b0, x} * {32'b0, y};
  endfunction

  function automatic int exp_cyc(input logic [31:0] x, input logic [31:0] y, input logic s);
    logic [31:0] m;
    int top;
    if (x == 0 || y == 0) return 0;
    m = (s && x[31]) ? (~x + 1) : x;
    top = 0;
    for (int i = 0; i < 32; i++) if (m[i]) top = i;
    return top + 1 + ((s && (x[31] ^ y[31])) ? 1 : 0);
  endfunction

  task automatic run_op(input logic [31:0] ta, input logic [31:0] tb, input logic ts,
                        output int cyc, output bit busy_ok);
    @(negedge clk);
    a = ta; b = tb; sgn = ts; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    busy_ok = 1'b1;
    while (!done && cyc < 100) begin
      if (!busy) busy_ok = 1'b0;
      cyc++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int cyc, ecyc;
    bit bok;
    logic [63:0] ep;
    logic [63:0] held;
    string ptag, ctag;

    repeat (3) @(negedge clk);
    check(!busy && !done && hi == 0 && lo == 0, "R1 reset state", {busy, done, hi, lo}, 64'h0);
    rst_n = 1'b1;

    foreach (VEC[k]) begin
      run_op(VEC[k][64:33], VEC[k][32:1], VEC[k][0], cyc, bok);
      ep   = exp_prod(VEC[k][64:33], VEC[k][32:1], VEC[k][0]);
      ecyc = exp_cyc(VEC[k][64:33], VEC[k][32:1], VEC[k][0]);
      ptag = (ecyc == 0) ? "R2 zero product" : (VEC[k][0] ? "R4 signed product" : "R3 unsigned product");
      ctag = (VEC[k][0] && ecyc != 0 && (VEC[k][64] ^ VEC[k][32])) ? "R10 negate latency" : "R5 latency";
      check({hi, lo} == ep, ptag, {hi, lo}, ep);
      check(cyc == ecyc, ctag, 64'(cyc), 64'(ecyc));
      check(bok, "R5 busy during run", 64'(bok), 64'd1);
      @(negedge clk);
      check(!done, "R6 done single pulse", 64'(done), 64'd0);
    end

    // R9: most negative value in signed mode
    run_op(32'h80000000, 32'h80000000, 1'b1, cyc, bok);
    check({hi, lo} == 64'h4000000000000000, "R9 min times min", {hi, lo}, 64'h4000000000000000);
    check(cyc == 32, "R9 latency", 64'(cyc), 64'd32);

    // R7: start while busy is ignored
    @(negedge clk);
    a = 32'hFFFFFFFF; b = 32'h00000003; sgn = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    repeat (2) @(negedge clk);
    cyc += 2;
    a = 32'h0; b = 32'h0; sgn = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc++;
    while (!done && cyc < 100) begin
      cyc++;
      @(negedge clk);
    end
    check(cyc == 33, "R7 timing unchanged", 64'(cyc), 64'd33);
    ep = 64'h00000002FFFFFFFD;
    check({hi, lo} == ep, "R7 result unchanged", {hi, lo}, ep);

    // R8: result holds while idle with inputs moving
    held = {hi, lo};
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      a = a + 32'h1111; b = ~b; sgn = ~sgn;
    end
    check({hi, lo} == held && !busy, "R8 result held", {hi, lo}, held);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule